// File: doc/BRIEF.md
# Nested Execution Lease Controller

This block hands the processor to a program for a bounded number of cycles and confines that program's data stores to a bounded address window. Software opens a lease by presenting a cycle budget, a return program counter and an address window (lowest and highest address, inclusive) on a one-cycle push request. Leases nest: a program running under a lease may open an inner lease, and the unit keeps all of them on a hardware stack. The stack pointer is held only in the controller and is never written from the data inputs, so it stays trusted whatever code is running.

Every cycle, every live entry's timer counts down, not just the top one. When a timer runs out, the unit sends the processor back to that entry's return address through a registered override pulse. It discards that entry and every entry above it, whatever the leased code was doing. The address window of the innermost live lease goes to the store-confinement logic. With no live lease, the whole address space is exported.

Top module: `lease_unit`

## Requirements
- R1: After reset the stack is empty: `leaseDepth` is 0, `leaseActive`, `pcOverrideValid` and `pushError` are low, `activeLo` is all zeros and `activeHi` is all ones.
- R2: A push sampled at clock edge k with free stack space raises `leaseDepth` by one after edge k, and `activeLo`/`activeHi` then show the pushed window.
- R3: A lease pushed at edge k with budget B (B >= 1) expires at edge k+B. After that edge `pcOverrideValid` is high with `pcOverride` equal to the lease's return PC, and the lease has been removed from the stack. No override appears before that edge.
- R4: A budget of 0 is loaded as 1, so the lease expires at the first edge after the push.
- R5: All live timers decrement each cycle. When an inner lease expires, the enclosing lease's window is exported again, and the enclosing lease still expires at the edge set by its own push and budget.
- R6: When an enclosing lease runs out while inner leases are live, or several leases run out at the same edge, the outermost expiring entry wins. Its return PC is issued, and the stack is cut back to the entries below it.
- R7: A push while the stack holds DEPTH entries is ignored. Depth and exported window stay unchanged, and `pushError` is high for exactly the one cycle after that edge.
- R8: A push sampled at the same edge as an expiry is dropped. The expiry is carried out as if no push were present, and `pushError` stays low.
- R9: With no live lease, the full address space is exported and `leaseActive` is low.
- R10: `pcOverrideValid` is a one-cycle pulse for each expiry. It falls in the following cycle unless another lease expires at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Open a new lease this cycle |
| pushBudget | input | TIMER_W | Cycle budget of the new lease |
| pushRetPc | input | PC_W | PC restored when the new lease expires |
| pushLo | input | ADDR_W | Lowest address of the new lease's window |
| pushHi | input | ADDR_W | Highest address of the new lease's window |
| pcOverrideValid | output | 1 | Registered: force the PC this cycle |
| pcOverride | output | PC_W | Registered PC to force |
| activeLo | output | ADDR_W | Lowest storable address now |
| activeHi | output | ADDR_W | Highest storable address now |
| leaseActive | output | 1 | At least one lease is live |
| leaseDepth | output | $clog2(DEPTH+1) | Number of live leases |
| pushError | output | 1 | Registered: previous push hit a full stack |

## Verification
A push request and a timer expiry can land on the same clock edge. So can the expiries of two nested leases. The bench provokes the first by pushing a second lease exactly B edges after a lease of budget B was opened. It judges the result by a single override carrying the first lease's return PC, an empty stack, the full address window and no error pulse. The bench provokes the second by choosing outer and inner budgets that end on the same edge, and expects one override with the outer return PC and an empty stack.

// File: rtl/lease_pkg.sv
package lease_pkg;

  // Strobes sent from the controller to the stack datapath each cycle.
  typedef struct packed {
    logic push;    // write the new lease into the free slot
    logic expire;  // an entry ran out; issue its return PC
  } lease_strobes_t;

endpackage

// File: rtl/lease_ctrl.sv
module lease_ctrl
  import lease_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushReq,
  input  logic [DEPTH-1:0] atOne,
  output lease_strobes_t   strb,
  output logic [DEPTH-1:0] liveMask,
  output logic [IDX_W-1:0] expIdx,
  output logic [CNT_W-1:0] stackPtr,
  output logic             pushError
);

  logic [CNT_W-1:0] spQ;
  logic [CNT_W-1:0] spNext;
  logic [DEPTH-1:0] hits;
  logic             stackFull;
  logic             anyHit;
  logic             errNext;

  // Entry i is live when it lies below the trusted stack pointer.
  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign liveMask[g] = (CNT_W'(g) < spQ);
  end

  assign hits      = atOne & liveMask;
  assign anyHit    = |hits;
  assign stackFull = (spQ == CNT_W'(DEPTH));

  // Outermost (lowest index) expiring entry wins.
  always_comb begin
    expIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) expIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.expire = anyHit;
    strb.push   = pushReq && !anyHit && !stackFull;
    errNext     = pushReq && !anyHit && stackFull;
    if (anyHit) begin
      spNext = CNT_W'(expIdx);
    end else if (strb.push) begin
      spNext = spQ + 1'b1;
    end else begin
      spNext = spQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spQ       <= '0;
      pushError <= 1'b0;
    end else begin
      spQ       <= spNext;
      pushError <= errNext;
    end
  end

  assign stackPtr = spQ;

endmodule

// File: rtl/lease_path.sv
module lease_path
  import lease_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int TIMER_W = 16,
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lease_strobes_t    strb,
  input  logic [DEPTH-1:0]  liveMask,
  input  logic [IDX_W-1:0]  expIdx,
  input  logic [CNT_W-1:0]  stackPtr,
  input  logic [TIMER_W-1:0] pushBudget,
  input  logic [PC_W-1:0]   pushRetPc,
  input  logic [ADDR_W-1:0] pushLo,
  input  logic [ADDR_W-1:0] pushHi,
  output logic [DEPTH-1:0]  atOne,
  output logic              pcOverrideValid,
  output logic [PC_W-1:0]   pcOverride,
  output logic [ADDR_W-1:0] activeLo,
  output logic [ADDR_W-1:0] activeHi
);

  logic [TIMER_W-1:0] timerQ [DEPTH];
  logic [PC_W-1:0]    retPcQ [DEPTH];
  logic [ADDR_W-1:0]  loQ    [DEPTH];
  logic [ADDR_W-1:0]  hiQ    [DEPTH];

  logic [TIMER_W-1:0] loadVal;
  logic [IDX_W-1:0]   pushSlot;
  logic [IDX_W-1:0]   topSlot;

  assign loadVal  = (pushBudget == '0) ? TIMER_W'(1) : pushBudget;
  assign pushSlot = IDX_W'(stackPtr);
  assign topSlot  = IDX_W'(stackPtr - 1'b1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_one
    assign atOne[g] = (timerQ[g] == TIMER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        timerQ[i] <= '0;
        retPcQ[i] <= '0;
        loQ[i]    <= '0;
        hiQ[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.push && pushSlot == IDX_W'(i)) begin
          timerQ[i] <= loadVal;
          retPcQ[i] <= pushRetPc;
          loQ[i]    <= pushLo;
          hiQ[i]    <= pushHi;
        end else if (liveMask[i]) begin
          timerQ[i] <= timerQ[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcOverrideValid <= 1'b0;
      pcOverride      <= '0;
    end else begin
      pcOverrideValid <= strb.expire;
      if (strb.expire) pcOverride <= retPcQ[expIdx];
    end
  end

  always_comb begin
    if (stackPtr == '0) begin
      activeLo = '0;
      activeHi = '1;
    end else begin
      activeLo = loQ[topSlot];
      activeHi = hiQ[topSlot];
    end
  end

endmodule

// File: rtl/lease_unit.sv
module lease_unit
  import lease_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int TIMER_W = 16,
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pushReq,
  input  logic [TIMER_W-1:0] pushBudget,
  input  logic [PC_W-1:0]    pushRetPc,
  input  logic [ADDR_W-1:0]  pushLo,
  input  logic [ADDR_W-1:0]  pushHi,
  output logic               pcOverrideValid,
  output logic [PC_W-1:0]    pcOverride,
  output logic [ADDR_W-1:0]  activeLo,
  output logic [ADDR_W-1:0]  activeHi,
  output logic               leaseActive,
  output logic [CNT_W-1:0]   leaseDepth,
  output logic               pushError
);

  lease_strobes_t   strb;
  logic [DEPTH-1:0] atOne;
  logic [DEPTH-1:0] liveMask;
  logic [IDX_W-1:0] expIdx;
  logic [CNT_W-1:0] stackPtr;

  lease_ctrl #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushReq(pushReq), .atOne(atOne),
    .strb(strb), .liveMask(liveMask), .expIdx(expIdx),
    .stackPtr(stackPtr), .pushError(pushError)
  );

  lease_path #(
    .DEPTH(DEPTH), .TIMER_W(TIMER_W), .PC_W(PC_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb), .liveMask(liveMask),
    .expIdx(expIdx), .stackPtr(stackPtr), .pushBudget(pushBudget),
    .pushRetPc(pushRetPc), .pushLo(pushLo), .pushHi(pushHi),
    .atOne(atOne), .pcOverrideValid(pcOverrideValid),
    .pcOverride(pcOverride), .activeLo(activeLo), .activeHi(activeHi)
  );

  assign leaseDepth  = stackPtr;
  assign leaseActive = (stackPtr != '0);

endmodule

// File: rtl/lease_unit_chk.sv
module lease_unit_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pcOverrideValid,
  input logic [ADDR_W-1:0] activeLo,
  input logic [ADDR_W-1:0] activeHi,
  input logic              leaseActive,
  input logic [CNT_W-1:0]  leaseDepth,
  input logic              pushError
);

  // R9
  idle_full_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !leaseActive |-> (activeLo == '0 && activeHi == '1));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leaseDepth <= CNT_W'(DEPTH));

  // R7
  err_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pushError |-> (leaseDepth == CNT_W'(DEPTH) && $stable(leaseDepth)));

  // R2
  single_step_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leaseDepth > $past(leaseDepth)) |-> (leaseDepth == $past(leaseDepth) + 1'b1));

  // R3
  override_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcOverrideValid |-> (leaseDepth < $past(leaseDepth)));

  // R8
  no_err_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcOverrideValid |-> !pushError);

endmodule

bind lease_unit lease_unit_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pcOverrideValid(pcOverrideValid),
  .activeLo(activeLo), .activeHi(activeHi), .leaseActive(leaseActive),
  .leaseDepth(leaseDepth), .pushError(pushError)
);

// File: tb/lease_unit_tb.sv
module lease_unit_tb;

  localparam int DEPTH   = 4;
  localparam int TIMER_W = 16;
  localparam int PC_W    = 16;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pushReq = 1'b0;
  logic [TIMER_W-1:0] pushBudget = '0;
  logic [PC_W-1:0]    pushRetPc = '0;
  logic [ADDR_W-1:0]  pushLo = '0;
  logic [ADDR_W-1:0]  pushHi = '0;
  logic               pcOverrideValid;
  logic [PC_W-1:0]    pcOverride;
  logic [ADDR_W-1:0]  activeLo;
  logic [ADDR_W-1:0]  activeHi;
  logic               leaseActive;
  logic [CNT_W-1:0]   leaseDepth;
  logic               pushError;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  lease_unit #(
    .DEPTH(DEPTH), .TIMER_W(TIMER_W), .PC_W(PC_W), .ADDR_W(ADDR_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pushReq(pushReq), .pushBudget(pushBudget),
    .pushRetPc(pushRetPc), .pushLo(pushLo), .pushHi(pushHi),
    .pcOverrideValid(pcOverrideValid), .pcOverride(pcOverride),
    .activeLo(activeLo), .activeHi(activeHi), .leaseActive(leaseActive),
    .leaseDepth(leaseDepth), .pushError(pushError)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; the push is sampled at the next rising edge,
  // and the task returns at the falling edge after it.
  task automatic doPush(input logic [TIMER_W-1:0] b, input logic [PC_W-1:0] pc,
                        input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    pushReq = 1'b1; pushBudget = b; pushRetPc = pc; pushLo = lo; pushHi = hi;
    @(posedge clk);
    @(negedge clk);
    pushReq = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && leaseDepth != '0; i++) @(negedge clk);
    waitCyc(2);
  endtask

  task automatic t_reset();
    check("R1", "depth", 32'(leaseDepth), 0);
    check("R1", "override valid", 32'(pcOverrideValid), 0);
    check("R1", "error", 32'(pushError), 0);
    check("R1", "lo", 32'(activeLo), 0);
    check("R1", "hi", 32'(activeHi), 32'hFFFF);
    waitCyc(5);
    check("R9", "idle active", 32'(leaseActive), 0);
    check("R9", "idle override", 32'(pcOverrideValid), 0);
  endtask

  task automatic t_single();
    doPush(16'd5, 16'h1234, 16'h0100, 16'h01FF);
    check("R2", "depth after push", 32'(leaseDepth), 1);
    check("R2", "lo", 32'(activeLo), 32'h0100);
    check("R2", "hi", 32'(activeHi), 32'h01FF);
    check("R2", "active", 32'(leaseActive), 1);
    waitCyc(4);
    check("R3", "no early override", 32'(pcOverrideValid), 0);
    waitCyc(1);
    check("R3", "override valid", 32'(pcOverrideValid), 1);
    check("R3", "override pc", 32'(pcOverride), 32'h1234);
    check("R3", "depth popped", 32'(leaseDepth), 0);
    check("R9", "lo after pop", 32'(activeLo), 0);
    check("R9", "hi after pop", 32'(activeHi), 32'hFFFF);
    waitCyc(1);
    check("R10", "pulse ends", 32'(pcOverrideValid), 0);
  endtask

  task automatic t_zero_budget();
    doPush(16'd0, 16'h0ABC, 16'h0010, 16'h0020);
    check("R4", "depth", 32'(leaseDepth), 1);
    check("R4", "not yet", 32'(pcOverrideValid), 0);
    waitCyc(1);
    check("R4", "override valid", 32'(pcOverrideValid), 1);
    check("R4", "override pc", 32'(pcOverride), 32'h0ABC);
    waitCyc(1);
  endtask

  task automatic t_nested();
    doPush(16'd20, 16'hA000, 16'h1000, 16'h1FFF);
    waitCyc(2);
    doPush(16'd5, 16'hB000, 16'h1400, 16'h14FF);
    check("R5", "depth two", 32'(leaseDepth), 2);
    check("R5", "inner lo", 32'(activeLo), 32'h1400);
    waitCyc(4);
    check("R5", "inner not yet", 32'(pcOverrideValid), 0);
    waitCyc(1);
    check("R5", "inner override", 32'(pcOverride), 32'hB000);
    check("R5", "inner valid", 32'(pcOverrideValid), 1);
    check("R5", "back to outer depth", 32'(leaseDepth), 1);
    check("R5", "outer lo restored", 32'(activeLo), 32'h1000);
    check("R5", "outer hi restored", 32'(activeHi), 32'h1FFF);
    waitCyc(11);
    check("R5", "outer not yet", 32'(pcOverrideValid), 0);
    check("R5", "outer still live", 32'(leaseDepth), 1);
    waitCyc(1);
    check("R5", "outer valid on time", 32'(pcOverrideValid), 1);
    check("R5", "outer pc", 32'(pcOverride), 32'hA000);
    waitCyc(1);
  endtask

  task automatic t_outer_first();
    doPush(16'd6, 16'hC000, 16'h2000, 16'h2FFF);
    doPush(16'd30, 16'hD000, 16'h2100, 16'h21FF);
    waitCyc(4);
    check("R6", "both live", 32'(leaseDepth), 2);
    waitCyc(1);
    check("R6", "outer valid", 32'(pcOverrideValid), 1);
    check("R6", "outer pc", 32'(pcOverride), 32'hC000);
    check("R6", "all discarded", 32'(leaseDepth), 0);
    waitCyc(30);
    check("R6", "discarded inner silent", 32'(pcOverrideValid), 0);
  endtask

  task automatic t_tie();
    doPush(16'd4, 16'hE000, 16'h3000, 16'h3FFF);
    doPush(16'd3, 16'hF000, 16'h3100, 16'h31FF);
    waitCyc(2);
    check("R6", "tie not yet", 32'(pcOverrideValid), 0);
    waitCyc(1);
    check("R6", "tie valid", 32'(pcOverrideValid), 1);
    check("R6", "tie outer pc", 32'(pcOverride), 32'hE000);
    check("R6", "tie depth", 32'(leaseDepth), 0);
    waitCyc(1);
    check("R10", "tie single pulse", 32'(pcOverrideValid), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      doPush(16'd100, 16'(16'h4000 + i), 16'(16'h4000 + 16'h100 * i),
             16'(16'h40FF + 16'h100 * i));
    end
    check("R7", "stack full", 32'(leaseDepth), DEPTH);
    doPush(16'd50, 16'h7777, 16'h7000, 16'h70FF);
    check("R7", "error pulse", 32'(pushError), 1);
    check("R7", "depth unchanged", 32'(leaseDepth), DEPTH);
    check("R7", "lo unchanged", 32'(activeLo), 32'h4300);
    check("R7", "hi unchanged", 32'(activeHi), 32'h43FF);
    waitCyc(1);
    check("R7", "error one cycle", 32'(pushError), 0);
    drain();
    check("R6", "drained by outermost", 32'(leaseDepth), 0);
  endtask

  task automatic t_collide();
    doPush(16'd3, 16'h5555, 16'h5000, 16'h50FF);
    waitCyc(2);
    doPush(16'd9, 16'h6666, 16'h6000, 16'h60FF);
    check("R8", "expiry wins", 32'(pcOverrideValid), 1);
    check("R8", "expiry pc", 32'(pcOverride), 32'h5555);
    check("R8", "push dropped", 32'(leaseDepth), 0);
    check("R8", "no error", 32'(pushError), 0);
    check("R8", "full range", 32'(activeHi), 32'hFFFF);
    waitCyc(12);
    check("R8", "dropped lease silent", 32'(pcOverrideValid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    t_reset();
    t_single();
    t_zero_budget();
    t_nested();
    t_outer_first();
    t_tie();
    t_full();
    t_collide();
    report();
    $finish;
  end

endmodule